// File: doc/BRIEF.md
# DMA channel control and status

This block is the control and status logic of one channel of a peripheral-to-memory DMA engine, seen through a small register port. Software programs a control word with an enable, interrupt enable, hold, direction, one-shot select, flow control, a peripheral request select and a word count. The channel then counts 32-bit words down as the data path reports each moved word on a transfer strobe. The block answers each accepted strobe with an acknowledge, raises an end-of-count flag and interrupt, and reports its progress in a status word.

Two modes are supported. In one-shot mode the channel stops after a single count and clears its own enable. In continuous mode the count describes half of a ping-pong buffer: at the end of every half the channel raises end-of-count, flips a ping-pong flag, reloads the count and keeps running. A global enable register pauses the channel without losing any state. Address generation and the data path are not part of the block.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the global, control and status words read as zero and the interrupt output is low.
- R2: Register address 0 holds the global enable in bit 31. Address 1 is the control word: bit 31 enable, bit 30 interrupt enable, bit 29 hold, bit 28 direction (1 = memory to peripheral), bit 27 one-shot, bit 21 flow control, bits 20:16 request select, bits 15:2 word count minus one; it reads back as written with all other bits zero. Address 2 is the status word: bit 31 busy, bit 30 end-of-count flag, bit 29 halt, bit 28 ping-pong, bits 15:2 remaining words minus one, all other bits zero.
- R3: A control write that sets the enable while the enable is clear loads the remaining count from the written word count, sets busy and clears ping-pong.
- R4: A word is accepted (word_ack high, remaining count decremented) only in a cycle where busy, enable and global enable are set, hold is clear, the transfer strobe is high and, with flow control on, the selected peripheral request line is high.
- R5: In one-shot mode the accept at remaining count zero sets the end-of-count flag, clears busy and the control enable bit, and reloads the count field with the word count.
- R6: In continuous mode the accept at remaining count zero sets the end-of-count flag, toggles ping-pong, reloads the word count and leaves the channel busy.
- R7: While global enable is clear or hold is set, no word is accepted and the count and ping-pong flag keep their values; halt reads 1 while busy and paused this way.
- R8: A status write with bit 30 set clears the end-of-count flag; with bit 30 clear it has no effect; a flag set in the same cycle as a clear stays set.
- R9: The interrupt output equals the end-of-count flag AND the interrupt enable; with interrupt enable clear the flag is still set.
- R10: A control write with the enable clear drops busy on the next cycle, keeps the remaining count readable and stops all further accepts.
- R11: No word is accepted in a cycle that writes the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_stb | input | 1 | Data path offers one 32-bit word |
| periph_req | input | NUM_REQ | Peripheral request lines |
| word_ack | output | 1 | Word accepted this cycle |
| irq | output | 1 | End-of-count interrupt |

## Verification
The bench aims at the count boundary: a word count of zero, the last word of a one-shot run and the wrap of a continuous run, where an off-by-one design would finish a word early or late, or fail to flip ping-pong. It collides a status clear with a new end-of-count, where a design with the wrong priority would lose an interrupt, and strobes during control writes, pauses, hold and unmatched flow-control requests, where a loose accept condition would move the count. It also disables mid-run and re-enables, where a design that reloads on every enable write or keeps busy set would restart or keep acknowledging.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    typedef enum logic [1:0] {
        REG_GLOBAL = 2'd0,
        REG_CTRL   = 2'd1,
        REG_STAT   = 2'd2
    } reg_sel_e;

    localparam int GEN_BIT   = 31;
    localparam int EN_BIT    = 31;
    localparam int IE_BIT    = 30;
    localparam int HOLD_BIT  = 29;
    localparam int DIR_BIT   = 28;
    localparam int ONCE_BIT  = 27;
    localparam int FLOW_BIT  = 21;
    localparam int SEL_LSB   = 16;
    localparam int CNT_LSB   = 2;
    localparam int BUSY_BIT  = 31;
    localparam int EOC_BIT   = 30;
    localparam int HALT_BIT  = 29;
    localparam int PP_BIT    = 28;
endpackage

// File: rtl/dmach_gate.sv
module dmach_gate #(
    parameter int NUM_REQ = 32,
    parameter int SEL_W   = $clog2(NUM_REQ)
) (
    input  logic               busy,
    input  logic               chan_en,
    input  logic               glob_en,
    input  logic               hold,
    input  logic               flow,
    input  logic [SEL_W-1:0]   sel,
    input  logic               stb,
    input  logic [NUM_REQ-1:0] req,
    input  logic               blocked,
    output logic               adv
);
    logic sel_hit;

    always_comb begin
        sel_hit = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (32'(sel) == i) sel_hit = req[i];
        end
        adv = busy && chan_en && glob_en && !hold && stb && !blocked
              && (!flow || sel_hit);
    end
endmodule

// File: rtl/dmach_counter.sv
module dmach_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             flip_en,
    output logic [CNT_W-1:0] remain,
    output logic             pp,
    output logic             terminal
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             pp;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.rem = load_val;
            cnt_d.pp  = 1'b0;
        end else if (step) begin
            if (cnt_q.rem == '0) begin
                cnt_d.rem = reload_val;
                if (flip_en) cnt_d.pp = !cnt_q.pp;
            end else begin
                cnt_d.rem = cnt_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign remain   = cnt_q.rem;
    assign pp       = cnt_q.pp;
    assign terminal = (cnt_q.rem == '0);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && remain != '0) |=> (remain == $past(remain) - 1'b1));

    // R6
    pp_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && terminal && flip_en) |=> (pp != $past(pp)));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain == $past(load_val) && !pp));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmach_pkg::*;
#(
    parameter int NUM_REQ = 32,
    parameter int SEL_W   = $clog2(NUM_REQ),
    parameter int CNT_W   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               xfer_stb,
    input  logic [NUM_REQ-1:0] periph_req,
    output logic               word_ack,
    output logic               irq
);
    typedef struct packed {
        logic             en;
        logic             ie;
        logic             hold;
        logic             dir;
        logic             once;
        logic             flow;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] wcount;
    } ctrl_t;

    typedef struct packed {
        logic  gen;
        ctrl_t ctrl;
        logic  busy;
        logic  eoc;
    } chan_t;

    chan_t            st_d, st_q;
    logic             wr_gen, wr_ctrl, wr_stat;
    logic             load, adv, terminal, pp, eoc_set, eoc_clr;
    logic [CNT_W-1:0] remain;

    assign wr_gen  = reg_wr && (reg_addr == REG_GLOBAL);
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_stat = reg_wr && (reg_addr == REG_STAT);
    assign load    = wr_ctrl && reg_wdata[EN_BIT] && !st_q.ctrl.en;
    assign eoc_set = adv && terminal;
    assign eoc_clr = wr_stat && reg_wdata[EOC_BIT];

    dmach_gate #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) i_gate (
        .busy    (st_q.busy),
        .chan_en (st_q.ctrl.en),
        .glob_en (st_q.gen),
        .hold    (st_q.ctrl.hold),
        .flow    (st_q.ctrl.flow),
        .sel     (st_q.ctrl.sel),
        .stb     (xfer_stb),
        .req     (periph_req),
        .blocked (wr_ctrl),
        .adv     (adv)
    );

    dmach_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata[CNT_LSB +: CNT_W]),
        .step       (adv),
        .reload_val (st_q.ctrl.wcount),
        .flip_en    (!st_q.ctrl.once),
        .remain     (remain),
        .pp         (pp),
        .terminal   (terminal)
    );

    always_comb begin
        st_d = st_q;
        if (wr_gen) st_d.gen = reg_wdata[GEN_BIT];
        if (wr_ctrl) begin
            st_d.ctrl.en     = reg_wdata[EN_BIT];
            st_d.ctrl.ie     = reg_wdata[IE_BIT];
            st_d.ctrl.hold   = reg_wdata[HOLD_BIT];
            st_d.ctrl.dir    = reg_wdata[DIR_BIT];
            st_d.ctrl.once   = reg_wdata[ONCE_BIT];
            st_d.ctrl.flow   = reg_wdata[FLOW_BIT];
            st_d.ctrl.sel    = reg_wdata[SEL_LSB +: SEL_W];
            st_d.ctrl.wcount = reg_wdata[CNT_LSB +: CNT_W];
            if (!reg_wdata[EN_BIT]) st_d.busy = 1'b0;
            if (load)               st_d.busy = 1'b1;
        end
        if (eoc_set && st_q.ctrl.once) begin
            st_d.busy    = 1'b0;
            st_d.ctrl.en = 1'b0;
        end
        st_d.eoc = eoc_set || (st_q.eoc && !eoc_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_GLOBAL: reg_rdata[GEN_BIT] = st_q.gen;
            REG_CTRL: begin
                reg_rdata[EN_BIT]               = st_q.ctrl.en;
                reg_rdata[IE_BIT]               = st_q.ctrl.ie;
                reg_rdata[HOLD_BIT]             = st_q.ctrl.hold;
                reg_rdata[DIR_BIT]              = st_q.ctrl.dir;
                reg_rdata[ONCE_BIT]             = st_q.ctrl.once;
                reg_rdata[FLOW_BIT]             = st_q.ctrl.flow;
                reg_rdata[SEL_LSB +: SEL_W]     = st_q.ctrl.sel;
                reg_rdata[CNT_LSB +: CNT_W]     = st_q.ctrl.wcount;
            end
            REG_STAT: begin
                reg_rdata[BUSY_BIT]             = st_q.busy;
                reg_rdata[EOC_BIT]              = st_q.eoc;
                reg_rdata[HALT_BIT]             = st_q.busy && (!st_q.gen || st_q.ctrl.hold);
                reg_rdata[PP_BIT]               = pp;
                reg_rdata[CNT_LSB +: CNT_W]     = remain;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign word_ack = adv;
    assign irq      = st_q.eoc && st_q.ctrl.ie;

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && terminal && st_q.ctrl.once) |=> (!st_q.busy && !st_q.ctrl.en));

    // R7
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.gen && !reg_wr) |=> ($stable(remain) && $stable(pp)));

    // R8
    eoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.eoc && !eoc_clr) |=> st_q.eoc);

    // R10
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !reg_wdata[EN_BIT]) |=> (!st_q.busy && $stable(remain)));

    // R11
    ctrl_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |-> !word_ack);

    // R6
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && terminal && !st_q.ctrl.once) |=> (st_q.busy && st_q.eoc));
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_stb = 1'b0;
    logic [31:0] periph_req = '0;
    logic        word_ack;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] last_rd;

    // behavioural model of the requirements
    logic        m_gen, m_en, m_ie, m_hold, m_dir, m_once, m_flow;
    logic [4:0]  m_sel;
    logic [13:0] m_wc, m_rem;
    logic        m_busy, m_pp, m_eoc;

    always #(CLK_NS/2) clk = ~clk;

    dma_chan_ctl i_dma_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_stb(xfer_stb),
        .periph_req(periph_req), .word_ack(word_ack), .irq(irq)
    );

    function automatic logic [31:0] exp_ctrl();
        return {m_en, m_ie, m_hold, m_dir, m_once, 5'b0, m_flow, m_sel, m_wc, 2'b0};
    endfunction

    function automatic logic exp_halt();
        return m_busy && (!m_gen || m_hold);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_gen, m_en, m_ie, m_hold, m_dir, m_once, m_flow} = '0;
        m_sel = '0; m_wc = '0; m_rem = '0;
        m_busy = 0; m_pp = 0; m_eoc = 0;
    endtask

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       input logic stb, input logic [31:0] req);
        logic e_adv, set_eoc, clr_eoc;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; xfer_stb = stb; periph_req = req;
        #1;
        e_adv = m_busy && m_en && m_gen && !m_hold && stb && (!m_flow || req[m_sel])
                && !(wr && a == 2'd1);
        chk("R4 word_ack", 32'(word_ack), 32'(e_adv));
        chk("R9 irq", 32'(irq), 32'(m_eoc && m_ie));
        last_rd = reg_rdata;
        if (!wr) begin
            if (a == 2'd0) chk("R2 global", reg_rdata, {m_gen, 31'b0});
            else if (a == 2'd1) chk("R2 control", reg_rdata, exp_ctrl());
            else if (a == 2'd2) begin
                chk("R10 busy", 32'(reg_rdata[31]), 32'(m_busy));
                chk("R8 eoc", 32'(reg_rdata[30]), 32'(m_eoc));
                chk("R7 halt", 32'(reg_rdata[29]), 32'(exp_halt()));
                chk("R6 pingpong", 32'(reg_rdata[28]), 32'(m_pp));
                chk("R3 remaining", 32'(reg_rdata[15:2]), 32'(m_rem));
                chk("R2 status zeros", {4'b0, reg_rdata[27:16], 14'b0, reg_rdata[1:0]}, 32'd0);
            end else chk("R2 unused", reg_rdata, 32'd0);
        end
        @(posedge clk);
        set_eoc = e_adv && (m_rem == 0);
        clr_eoc = wr && a == 2'd2 && wd[30];
        if (e_adv) begin
            if (m_rem == 0) begin
                m_rem = m_wc;
                if (m_once) begin m_busy = 0; m_en = 0; end
                else m_pp = !m_pp;
            end else m_rem = m_rem - 1;
        end
        m_eoc = set_eoc || (m_eoc && !clr_eoc);
        if (wr && a == 2'd0) m_gen = wd[31];
        if (wr && a == 2'd1) begin
            if (wd[31] && !m_en) begin m_rem = wd[15:2]; m_busy = 1; m_pp = 0; end
            if (!wd[31]) m_busy = 0;
            {m_en, m_ie, m_hold, m_dir, m_once} = wd[31:27];
            m_flow = wd[21]; m_sel = wd[20:16]; m_wc = wd[15:2];
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, ie, hold, once, flow,
                                            input logic [4:0] sel, input logic [13:0] wc);
        return {en, ie, hold, 1'b0, once, 5'b0, flow, sel, wc, 2'b0};
    endfunction

    task automatic rd(input logic [1:0] a); cyc(0, a, 32'd0, 0, 32'd0); endtask
    task automatic stb_n(input int n); for (int i = 0; i < n; i++) cyc(0, 2'd2, 0, 1, 32'hFFFF_FFFF); endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(2'd1); chk("R1 ctrl after reset", last_rd, 32'd0);
        rd(2'd2); chk("R1 status after reset", last_rd, 32'd0);
        rd(2'd0); chk("R1 global after reset", last_rd, 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);

        // R7: strobes with global enable clear are not accepted
        cyc(1, 2'd1, mk_ctrl(1, 1, 0, 1, 0, 5'd0, 14'd2), 0, 0);
        stb_n(3);
        rd(2'd2); chk("R7 frozen count", 32'(last_rd[15:2]), 32'd2);
        chk("R7 halt while paused", 32'(last_rd[29]), 32'd1);

        // R5: one-shot, three words
        cyc(1, 2'd0, 32'h8000_0000, 0, 0);
        stb_n(3);
        rd(2'd2); chk("R5 eoc after one-shot", 32'(last_rd[31:30]), 32'b01);
        rd(2'd1); chk("R5 enable cleared", 32'(last_rd[31]), 32'd0);
        chk("R9 irq raised", 32'(irq), 32'd1);
        // R8: clear with bit 30 low has no effect, then with bit 30 high
        cyc(1, 2'd2, 32'hBFFF_FFFF, 0, 0);
        rd(2'd2); chk("R8 no clear without bit30", 32'(last_rd[30]), 32'd1);
        cyc(1, 2'd2, 32'h4000_0000, 0, 0);
        rd(2'd2); chk("R8 cleared", 32'(last_rd[30]), 32'd0);

        // R6: continuous, word count 0 -> every word wraps
        cyc(1, 2'd1, mk_ctrl(1, 0, 0, 0, 0, 5'd0, 14'd0), 0, 0);
        stb_n(1);
        rd(2'd2); chk("R6 pp after first half", 32'(last_rd[31:28]), 32'b1101);
        chk("R9 irq masked", 32'(irq), 32'd0);
        // R8: set and clear in the same cycle, set wins
        cyc(1, 2'd2, 32'h4000_0000, 1, 32'hFFFF_FFFF);
        rd(2'd2); chk("R8 set beats clear", 32'(last_rd[30]), 32'd1);
        chk("R6 pp back", 32'(last_rd[28]), 32'd0);

        // R11: control write with strobe, not accepted
        cyc(1, 2'd1, mk_ctrl(1, 0, 0, 0, 0, 5'd3, 14'd5), 1, 32'hFFFF_FFFF);
        // R10: disable mid-run freezes count
        stb_n(2);
        cyc(1, 2'd1, mk_ctrl(0, 0, 0, 0, 0, 5'd3, 14'd5), 1, 32'hFFFF_FFFF);
        stb_n(2);
        rd(2'd2); chk("R10 busy low", 32'(last_rd[31]), 32'd0);
        // R3: re-enable reloads from written count
        cyc(1, 2'd1, mk_ctrl(1, 0, 0, 0, 1, 5'd3, 14'd4), 0, 0);
        rd(2'd2); chk("R3 reload", 32'(last_rd[15:2]), 32'd4);
        // R4: flow control, only selected request counts
        cyc(0, 2'd2, 0, 1, 32'hFFFF_FFF7);
        cyc(0, 2'd2, 0, 1, 32'h0000_0008);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic [31:0] wd;
            r = int'($urandom % 100);
            wd = $urandom;
            if (r < 6) begin
                wd = mk_ctrl(($urandom % 5) != 0, wd[30], ($urandom % 10) == 0, wd[27],
                             ($urandom % 3) == 0, 5'($urandom % 4), 14'($urandom % 6));
                wd[28] = $urandom;
                cyc(1, 2'd1, wd, $urandom % 2, $urandom);
            end else if (r < 9) begin
                cyc(1, 2'd0, {($urandom % 4) != 0, 31'($urandom)}, $urandom % 2, $urandom);
            end else if (r < 14) begin
                cyc(1, 2'd2, wd, $urandom % 2, $urandom);
            end else begin
                logic [1:0] a;
                a = (r < 20) ? 2'($urandom % 4) : 2'd2;
                cyc(0, a, 0, ($urandom % 10) < 6, $urandom);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule